// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block sits beside an in-order issue stage. It keeps one bit for each architectural register, and that bit is set while a result write to the register is still owed. Each cycle the stage presents one candidate instruction on a valid/ready handshake. The candidate carries its source register numbers with read-enables and its destination register numbers with write-enables. The scoreboard answers with three signals:

- a read hazard, meaning a source is still being produced;
- a write-after-write hazard, meaning a destination is already owed a write;
- the accept signal `iss_ready`.

Write-back ports, each an enable plus a register number, release the bits. Work that belongs elsewhere is left out: the register file, operand routing and unit arbitration.

When an instruction is accepted, its destination mask goes into a staging register and is folded into the pending vector on the next edge. Hazard checks look at the pending vector OR the staging register. The next instruction therefore sees the earlier write, but an instruction never sees its own write. The clears from all write-back ports are OR-merged into one vector before they are applied. A write-after-write hit withholds `iss_ready`, so the stage keeps the same decode on the inputs and the check repeats every cycle. A read hazard is reported as a flag only; it does not stall.

Back-pressure rules: `iss_ready` can be low whether or not `iss_valid` is high. A transfer happens on an edge where both are high. While `iss_ready` is low, the stage must hold its payload stable.

Top module: `wpend_scoreboard`

## Requirements
- R1: Synchronous reset (`rst` high at an edge) clears every pending bit and the staging register, so the first instruction after reset sees no hazard.
- R2: An accepted instruction's enabled destination registers become pending from the edge after the accepting one. The next instruction in the cycle right after acceptance already sees them.
- R3: An instruction that reads and writes the same register, with that register not pending, reports no hazard against itself and is accepted.
- R4: `raw_hazard` is high exactly when `iss_valid` is high and some enabled source register is pending. Disabled sources are ignored.
- R5: `waw_hazard` is high exactly when `iss_valid` is high and some enabled destination register is pending. Disabled destinations are ignored.
- R6: `iss_ready` equals NOT `waw_hazard` AND NOT `core_busy`. A stalled instruction is accepted in the first cycle after the blocking write-back has cleared its bit.
- R7: A write-back with its enable high clears the pending bit of its register at that edge. Write-backs on several ports in one cycle all take effect.
- R8: If a staged set and a write-back clear hit the same bit at the same edge, the bit stays pending.
- R9: `core_busy` is high when any unit selected by the `SERIAL_UNITS` mask reports busy (bit i of `unit_busy` is unit i). While it is high, nothing is accepted.
- R10: With `UNARY`=0, a register number k selects bit k of the pending vector. With `UNARY`=1, each number field is itself a one-hot mask of NREG bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Candidate instruction present |
| iss_ready | output | 1 | Candidate accepted this cycle if valid |
| iss_src_num | input | NSRC*NUM_W | Source register numbers |
| iss_src_en | input | NSRC | Source read-enables |
| iss_dst_num | input | NDST*NUM_W | Destination register numbers |
| iss_dst_en | input | NDST | Destination write-enables |
| wb_en | input | NWB | Write-back port enables |
| wb_num | input | NWB*NUM_W | Write-back register numbers |
| unit_busy | input | NUNIT | Busy flag of each execution unit |
| raw_hazard | output | 1 | Enabled source is pending |
| waw_hazard | output | 1 | Enabled destination is pending |
| core_busy | output | 1 | A serialising unit is busy |

## Verification
Random streams with a fixed seed are the main load. They mix valid and idle cycles, random enables on the sources and destinations, and write-backs aimed mostly at registers that are really pending. Every cycle, all four outputs are compared with a bench model of the pending and staging state. Directed sequences cover the cases random traffic rarely produces:

- A back-to-back dependent pair shows that the staged set is visible before it is folded into the pending vector.
- A register that is both read and written separates a self-hazard from a true one.
- A write-after-write stall released by a write-back on the second port shows that the stall lifts in exactly the right cycle.
- Two ports clearing at once show that no clear is lost.
- A set and a clear in the same cycle show which of the two has priority.
- A cycle with a serial unit busy shows that acceptance is blocked.

// File: rtl/swp_pkg.sv
package swp_pkg;
  function automatic int num_width(input int nreg, input bit unary);
    return unary ? nreg : ((nreg > 1) ? $clog2(nreg) : 1);
  endfunction
endpackage

// File: rtl/swp_onehot.sv
// Turns N register-number fields into one OR-merged register mask.
module swp_onehot #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int NUM_W = 5,
  parameter int N     = 2
) (
  input  logic [N-1:0][NUM_W-1:0] num,
  input  logic [N-1:0]            en,
  output logic [NREG-1:0]         mask
);
  logic [N-1:0][NREG-1:0] per_field;

  for (genvar i = 0; i < N; i++) begin : g_field
    if (UNARY) begin : g_unary
      assign per_field[i] = en[i] ? NREG'(num[i]) : '0;
    end else begin : g_binary
      assign per_field[i] = en[i] ? (NREG'(1) << num[i]) : '0;
    end
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < N; i++) mask |= per_field[i];
  end
endmodule

// File: rtl/swp_pend_vec.sv
// Pending-write state with a one-cycle staged set path.
module swp_pend_vec #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_fire,
  input  logic [NREG-1:0] set_mask,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] pend_q,
  output logic [NREG-1:0] stage_q,
  output logic [NREG-1:0] view
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      stage_q <= '0;
    end else begin
      // staged set applied after the clear: newer instruction wins
      pend_q  <= (pend_q & ~clr_mask) | stage_q;
      stage_q <= set_fire ? set_mask : '0;
    end
  end

  assign view = pend_q | stage_q;
endmodule

// File: rtl/swp_hazard.sv
// Hazard detection and issue acceptance.
module swp_hazard #(
  parameter int NREG  = 32,
  parameter int NUNIT = 6,
  parameter logic [NUNIT-1:0] SERIAL_UNITS = '0
) (
  input  logic             valid,
  input  logic [NREG-1:0]  view,
  input  logic [NREG-1:0]  src_mask,
  input  logic [NREG-1:0]  dst_mask,
  input  logic [NUNIT-1:0] unit_busy,
  output logic             raw_hit,
  output logic             waw_hit,
  output logic             serial_busy,
  output logic             accept_ok
);
  assign raw_hit     = valid & (|(view & src_mask));
  assign waw_hit     = valid & (|(view & dst_mask));
  assign serial_busy = |(unit_busy & SERIAL_UNITS);
  assign accept_ok   = ~waw_hit & ~serial_busy;
endmodule

// File: rtl/wpend_scoreboard.sv
module wpend_scoreboard #(
  parameter int NREG  = 32,
  parameter bit UNARY = 1'b0,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int NWB   = 2,
  parameter int NUNIT = 6,
  parameter logic [NUNIT-1:0] SERIAL_UNITS = 6'b011110,
  localparam int NUM_W = swp_pkg::num_width(NREG, UNARY)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       iss_valid,
  output logic                       iss_ready,
  input  logic [NSRC-1:0][NUM_W-1:0] iss_src_num,
  input  logic [NSRC-1:0]            iss_src_en,
  input  logic [NDST-1:0][NUM_W-1:0] iss_dst_num,
  input  logic [NDST-1:0]            iss_dst_en,
  input  logic [NWB-1:0]             wb_en,
  input  logic [NWB-1:0][NUM_W-1:0]  wb_num,
  input  logic [NUNIT-1:0]           unit_busy,
  output logic                       raw_hazard,
  output logic                       waw_hazard,
  output logic                       core_busy
);
  logic [NREG-1:0] src_mask, dst_mask, clr_mask;
  logic [NREG-1:0] pend_q, stage_q, view;
  logic            fire;

  swp_onehot #(.NREG(NREG), .UNARY(UNARY), .NUM_W(NUM_W), .N(NSRC)) u_src (
    .num(iss_src_num), .en(iss_src_en), .mask(src_mask));
  swp_onehot #(.NREG(NREG), .UNARY(UNARY), .NUM_W(NUM_W), .N(NDST)) u_dst (
    .num(iss_dst_num), .en(iss_dst_en), .mask(dst_mask));
  // all write-back ports merged into a single clear vector
  swp_onehot #(.NREG(NREG), .UNARY(UNARY), .NUM_W(NUM_W), .N(NWB)) u_clr (
    .num(wb_num), .en(wb_en), .mask(clr_mask));

  swp_hazard #(.NREG(NREG), .NUNIT(NUNIT), .SERIAL_UNITS(SERIAL_UNITS)) u_haz (
    .valid(iss_valid), .view(view), .src_mask(src_mask), .dst_mask(dst_mask),
    .unit_busy(unit_busy), .raw_hit(raw_hazard), .waw_hit(waw_hazard),
    .serial_busy(core_busy), .accept_ok(iss_ready));

  assign fire = iss_valid & iss_ready;

  swp_pend_vec #(.NREG(NREG)) u_pend (
    .clk(clk), .rst(rst), .set_fire(fire), .set_mask(dst_mask),
    .clr_mask(clr_mask), .pend_q(pend_q), .stage_q(stage_q), .view(view));
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fire,
  input logic            waw_hazard,
  input logic            core_busy,
  input logic            iss_ready,
  input logic [NREG-1:0] dst_mask,
  input logic [NREG-1:0] clr_mask,
  input logic [NREG-1:0] pend_q,
  input logic [NREG-1:0] stage_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && stage_q == '0));

  a_r2_staged_set: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((stage_q & $past(dst_mask)) == $past(dst_mask)));

  a_r6_waw_blocks: assert property (@(posedge clk) disable iff (rst)
    waw_hazard |-> !iss_ready);

  a_r7_clear_applied: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((pend_q & $past(clr_mask & ~stage_q)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (stage_q != '0) |=> ((pend_q & $past(stage_q)) == $past(stage_q)));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    core_busy |-> !iss_ready);
endmodule

bind wpend_scoreboard swp_checker #(.NREG(NREG)) chk_i (
  .clk(clk), .rst(rst), .fire(fire), .waw_hazard(waw_hazard),
  .core_busy(core_busy), .iss_ready(iss_ready), .dst_mask(dst_mask),
  .clr_mask(clr_mask), .pend_q(pend_q), .stage_q(stage_q));

// File: tb/wpend_scoreboard_tb_top.sv
`timescale 1ns/1ps
module wpend_scoreboard_tb_top;
  localparam int NREG = 32, NSRC = 3, NDST = 2, NWB = 2, NUNIT = 6, NW = 5;
  localparam logic [NUNIT-1:0] SER = 6'b011110;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid, iss_ready, raw_hazard, waw_hazard, core_busy;
  logic [NSRC-1:0][NW-1:0] src_num;
  logic [NSRC-1:0] src_en;
  logic [NDST-1:0][NW-1:0] dst_num;
  logic [NDST-1:0] dst_en;
  logic [NWB-1:0] wb_en;
  logic [NWB-1:0][NW-1:0] wb_num;
  logic [NUNIT-1:0] unit_busy;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [NREG-1:0] m_pend = '0, m_stage = '0;

  always #4 clk = ~clk;  // 125 MHz

  wpend_scoreboard dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_num(src_num), .iss_src_en(src_en), .iss_dst_num(dst_num),
    .iss_dst_en(dst_en), .wb_en(wb_en), .wb_num(wb_num), .unit_busy(unit_busy),
    .raw_hazard(raw_hazard), .waw_hazard(waw_hazard), .core_busy(core_busy));

  function automatic logic [NREG-1:0] src_m();
    logic [NREG-1:0] m = '0;
    for (int i = 0; i < NSRC; i++) if (src_en[i]) m[src_num[i]] = 1'b1;
    return m;
  endfunction
  function automatic logic [NREG-1:0] dst_m();
    logic [NREG-1:0] m = '0;
    for (int i = 0; i < NDST; i++) if (dst_en[i]) m[dst_num[i]] = 1'b1;
    return m;
  endfunction
  function automatic logic [NREG-1:0] wb_m();
    logic [NREG-1:0] m = '0;
    for (int i = 0; i < NWB; i++) if (wb_en[i]) m[wb_num[i]] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    iss_valid = 0; src_en = '0; dst_en = '0; wb_en = '0; unit_busy = '0;
    src_num = '0; dst_num = '0; wb_num = '0;
  endtask

  // inputs are set just after a negedge; compare, then advance model
  task automatic step(input string tag);
    logic [NREG-1:0] v;
    logic e_raw, e_waw, e_busy, e_rdy;
    #1;
    v = m_pend | m_stage;
    e_raw  = iss_valid && ((v & src_m()) != '0);   // R4
    e_waw  = iss_valid && ((v & dst_m()) != '0);   // R5
    e_busy = (unit_busy & SER) != '0;              // R9
    e_rdy  = !e_waw && !e_busy;                    // R6
    chk(tag, "raw_hazard", raw_hazard, e_raw);
    chk(tag, "waw_hazard", waw_hazard, e_waw);
    chk(tag, "core_busy", core_busy, e_busy);
    chk(tag, "iss_ready", iss_ready, e_rdy);
    @(posedge clk);
    m_pend  = (m_pend & ~wb_m()) | m_stage;        // R7 R8
    m_stage = (iss_valid && e_rdy) ? dst_m() : '0; // R2
    @(negedge clk);
  endtask

  task automatic instr(input logic [NW-1:0] s0, input bit se0, input logic [NW-1:0] d0,
                       input bit de0);
    iss_valid = 1; src_num = '0; src_en = '0; dst_num = '0; dst_en = '0;
    src_num[0] = s0; src_en[0] = se0; dst_num[0] = d0; dst_en[0] = de0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: after reset, reading/writing anything is hazard-free
    instr(5'd3, 1, 5'd3, 0); src_en = '1; src_num[1] = 5'd31; src_num[2] = 5'd0;
    step("R1");
    idle_in(); step("R1");
    // R3: r5 <- r5 + imm, no self hazard, accepted
    instr(5'd5, 1, 5'd5, 1); step("R3");
    // R2: dependent instruction right behind sees r5 via staging
    instr(5'd5, 1, 5'd6, 1); step("R2");
    // R10: bit position, r4 not pending while r5/r6 are
    instr(5'd4, 1, 5'd0, 0); step("R10");
    // R4 disabled source ignored
    instr(5'd5, 0, 5'd0, 0); step("R4");
    // R5: WAW on r6 stalls, wb on port1 releases
    instr(5'd1, 0, 5'd6, 1); step("R5");
    wb_en[1] = 1; wb_num[1] = 5'd6; step("R6");
    wb_en = '0; step("R6");
    idle_in(); step("R6");
    // R7: two ports clearing r5 and r6 at once
    wb_en = 2'b11; wb_num[0] = 5'd5; wb_num[1] = 5'd6; step("R7");
    wb_en = '0; instr(5'd5, 1, 5'd6, 1); src_num[1] = 5'd6; src_en[1] = 1; step("R7");
    // R8: staged set of r6 meets a clear of r6
    idle_in(); wb_en[0] = 1; wb_num[0] = 5'd6; step("R8");
    wb_en = '0; instr(5'd0, 0, 5'd6, 1); step("R8");
    // R9: serial unit busy blocks; non-serial unit does not
    idle_in(); wb_en[0] = 1; wb_num[0] = 5'd6; step("R9");
    instr(5'd2, 1, 5'd9, 1); unit_busy = 6'b000100; step("R9");
    unit_busy = 6'b100001; step("R9");
    idle_in(); step("R9");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NREG-1:0] pv;
      pv = m_pend;
      iss_valid = ($urandom % 4) != 0;
      for (int i = 0; i < NSRC; i++) begin
        src_num[i] = NW'($urandom); src_en[i] = $urandom % 2;
      end
      for (int i = 0; i < NDST; i++) begin
        dst_num[i] = NW'($urandom % 12); dst_en[i] = ($urandom % 3) == 0;
      end
      for (int i = 0; i < NWB; i++) begin
        wb_en[i] = ($urandom % 2) && (pv != '0);
        wb_num[i] = NW'($urandom % 12);
        for (int k = 0; k < 12; k++) if (pv[(wb_num[i] + k) % 12]) begin
          wb_num[i] = NW'((wb_num[i] + k) % 12);
          break;
        end
      end
      unit_busy = (($urandom % 8) == 0) ? NUNIT'($urandom) : '0;
      step("R4/R5 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule